// File: doc/BRIEF.md
# Gated Window Frequency Meter

This block compares a fast on-chip oscillator with the system reference clock. Software opens a measurement window by setting a start bit. The window lasts a programmed number of oscillator cycles. While the window is open, the block counts reference-clock cycles. When the window closes, the block latches the reference count into a result register and raises a sticky valid flag, which software polls.

Counting only goes ahead while a separate free-run gate input is high. Lowering the gate pauses both sides of the measurement without losing progress. The start bit and the window length live in the reference domain. The window length is captured when a measurement starts and is held stable for the oscillator side to read. The run and gate levels reach the oscillator domain through two-flop synchronizers. The window-done and busy levels come back the same way. A measurement only begins once the oscillator side has shown, through those returned levels, that it is idle and cleared.

A window length of zero finishes at once with a result of zero. Software treats a zero result as a failed measurement.

Top module: `freq_meter`

## Requirements
- R1: After reset, `meas_valid` is 0 and `meas_count` is 0.
- R2: With `frun_en` held high and a window of N>0 oscillator periods, `meas_valid` rises and `meas_count` lies between N·Tosc/Tref−1 and N·Tosc/Tref + 4·Tosc/Tref + 6, where Tosc and Tref are the two clock periods.
- R3: Once `meas_valid` is 1, it stays 1 and `meas_count` stays constant for as long as `meas_start` stays high.
- R4: Clearing `meas_start` drives `meas_valid` to 0 at the next reference edge.
- R5: `meas_count` keeps its value while `meas_start` is low. It is cleared to 0 on the reference edge that starts the next measurement.
- R6: A window length of 0 gives `meas_valid`=1 and `meas_count`=0 one reference edge after the start.
- R7: While `frun_en` is low, no counting happens and `meas_valid` stays 0. When `frun_en` is raised, the result covers only gated time and meets the R2 band.
- R8: Clearing `meas_start` in the middle of a window abandons that window. The next start gives a fresh result for the new window length that meets the R2 band, with no stale completion.
- R9: The reference count saturates at all ones of `RES_W` bits rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the control and status side |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk | input | 1 | Measured oscillator clock |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| meas_start | input | 1 | Start bit; high runs a measurement, low stops and clears valid |
| frun_en | input | 1 | Free-run gate; counting proceeds only while high |
| win_len | input | WIN_W | Window length in oscillator cycles |
| meas_valid | output | 1 | Sticky completion flag |
| meas_count | output | RES_W | Reference cycles counted during the window |

## Verification
The bench builds two copies of the meter. The first uses the default 24-bit window and 32-bit result. It runs windows of 0, 1, 37, 50, 200 and 1024 cycles against oscillator periods slower and faster than the reference. The second copy shares all inputs but has an 8-bit result. A 1024-cycle window at a 7 ns oscillator period then drives its reference count past 255, so the saturation limit can be reached in a short run. Every completion is checked against a tolerance band computed from the two periods and the synchronizer latency.

// File: rtl/freq_meter_pkg.sv
`timescale 1ns/1ps
package freq_meter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_sync_2ff.sv
`timescale 1ns/1ps
module fm_sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/fm_osc_window.sv
`timescale 1ns/1ps
module fm_osc_window #(
  parameter int WIN_W = 24
) (
  input  logic             osc_clk,
  input  logic             osc_rst,
  input  logic             active_i,
  input  logic             gate_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             done_o,
  output logic             busy_o
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] cnt_nx;
  logic             done_q;
  logic             busy_q;

  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= active_i;
      if (!active_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (gate_i && !done_q) begin
        cnt_q <= cnt_nx;
        if (cnt_nx == win_i) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign busy_o = busy_q;

  // R2: window completion is held until the run level is withdrawn
  assert_done_hold_R2: assert property (@(posedge osc_clk) disable iff (osc_rst)
    (done_q && active_i) |=> done_q);
endmodule

// File: rtl/fm_ref_ctrl.sv
`timescale 1ns/1ps
module fm_ref_ctrl
  import freq_meter_pkg::*;
#(
  parameter int WIN_W = 24,
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_start,
  input  logic             frun_en,
  input  logic [WIN_W-1:0] win_len,
  input  logic             done_s,
  input  logic             busy_s,
  output logic             active_o,
  output logic             gate_o,
  output logic [WIN_W-1:0] win_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  localparam logic [RES_W-1:0] RES_MAX = {RES_W{1'b1}};

  fm_state_e        state_q, state_nx;
  logic [RES_W-1:0] cnt_q;
  logic [RES_W-1:0] result_q;
  logic [WIN_W-1:0] win_q;
  logic             valid_q;
  logic             active_q;
  logic             gate_q;

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE: begin
        if (meas_start) state_nx = (win_len == '0) ? ST_DONE : ST_FLUSH;
      end
      ST_FLUSH: begin
        if (!meas_start)          state_nx = ST_IDLE;
        else if (!busy_s && !done_s) state_nx = ST_RUN;
      end
      ST_RUN: begin
        if (!meas_start)  state_nx = ST_IDLE;
        else if (done_s)  state_nx = ST_DONE;
      end
      default: begin
        if (!meas_start) state_nx = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      result_q <= '0;
      win_q    <= '0;
      valid_q  <= 1'b0;
      active_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      state_q  <= state_nx;
      valid_q  <= (state_nx == ST_DONE);
      active_q <= (state_nx == ST_RUN) || (state_nx == ST_DONE);
      gate_q   <= (state_nx == ST_RUN) && frun_en;
      if (state_q == ST_IDLE && meas_start) begin
        win_q    <= win_len;
        cnt_q    <= '0;
        result_q <= '0;
      end else if (state_q == ST_RUN && meas_start) begin
        if (done_s)                          result_q <= cnt_q;
        else if (frun_en && cnt_q != RES_MAX) cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign gate_o   = gate_q;
  assign win_o    = win_q;
  assign valid_o  = valid_q;
  assign result_o = result_q;

  assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && meas_start) |=> valid_q);
  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (rst)
    !meas_start |=> !valid_q);
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !meas_start |=> $stable(result_q));
  assert_zero_window_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && meas_start && win_len == '0) |=> (valid_q && result_q == '0));
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && meas_start && cnt_q == RES_MAX) |=> (cnt_q == RES_MAX));
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter #(
  parameter int WIN_W = 24,
  parameter int RES_W = 32
) (
  input  logic             ref_clk,
  input  logic             ref_rst,
  input  logic             osc_clk,
  input  logic             osc_rst,
  input  logic             meas_start,
  input  logic             frun_en,
  input  logic [WIN_W-1:0] win_len,
  output logic             meas_valid,
  output logic [RES_W-1:0] meas_count
);
  logic             active_r, gate_r;
  logic [WIN_W-1:0] win_r;
  logic [1:0]       to_osc_s;
  logic             done_o, busy_o;
  logic [1:0]       to_ref_s;

  fm_ref_ctrl #(.WIN_W(WIN_W), .RES_W(RES_W)) u_ctrl (
    .clk        (ref_clk),
    .rst        (ref_rst),
    .meas_start (meas_start),
    .frun_en    (frun_en),
    .win_len    (win_len),
    .done_s     (to_ref_s[0]),
    .busy_s     (to_ref_s[1]),
    .active_o   (active_r),
    .gate_o     (gate_r),
    .win_o      (win_r),
    .valid_o    (meas_valid),
    .result_o   (meas_count)
  );

  fm_sync_2ff #(.W(2)) u_sync_to_osc (
    .clk (osc_clk),
    .rst (osc_rst),
    .d   ({gate_r, active_r}),
    .q   (to_osc_s)
  );

  // win_r is captured before the run level rises and stays fixed while it is high
  fm_osc_window #(.WIN_W(WIN_W)) u_osc (
    .osc_clk  (osc_clk),
    .osc_rst  (osc_rst),
    .active_i (to_osc_s[0]),
    .gate_i   (to_osc_s[1]),
    .win_i    (win_r),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  fm_sync_2ff #(.W(2)) u_sync_to_ref (
    .clk (ref_clk),
    .rst (ref_rst),
    .d   ({busy_o, done_o}),
    .q   (to_ref_s)
  );
endmodule

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
  localparam real TREF = 5.0;

  logic        clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_rst = 1'b1;
  logic        meas_start = 1'b0;
  logic        frun_en = 1'b0;
  logic [23:0] win_len = '0;
  logic        valid, sat_valid;
  logic [31:0] count;
  logic [7:0]  sat_count;
  real         osc_half = 3.5;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct { real lo; real hi; string req; } band_t;
  band_t exp_q[$];

  always #(TREF/2.0) clk = ~clk;
  always #(osc_half) osc_clk = ~osc_clk;

  freq_meter dut_i (
    .ref_clk(clk), .ref_rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
    .meas_start(meas_start), .frun_en(frun_en), .win_len(win_len),
    .meas_valid(valid), .meas_count(count));

  freq_meter #(.WIN_W(24), .RES_W(8)) dut_sat_i (
    .ref_clk(clk), .ref_rst(rst), .osc_clk(osc_clk), .osc_rst(osc_rst),
    .meas_start(meas_start), .frun_en(frun_en), .win_len(win_len),
    .meas_valid(sat_valid), .meas_count(sat_count));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_band(input int win, input real tosc, input string req);
    band_t b;
    real ideal;
    ideal = win * tosc / TREF;
    b.lo = (win == 0) ? 0.0 : ideal - 1.0;
    b.hi = (win == 0) ? 0.0 : ideal + 4.0 * tosc / TREF + 6.0;
    b.req = req;
    exp_q.push_back(b);
  endtask

  // monitor: compare each completion with the oldest expected band
  logic valid_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && valid && !valid_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", longint'(count), -1);
      end else begin
        band_t b;
        b = exp_q.pop_front();
        n_checks++;
        if (real'(count) < b.lo || real'(count) > b.hi) begin
          n_fail++;
          $display("FAIL %s actual=%0d expected=%0d..%0d", b.req, count,
                   longint'(b.lo), longint'(b.hi));
        end
      end
    end
    valid_prev <= valid;
  end

  task automatic wait_valid(input string req);
    int k = 0;
    while (!valid && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(valid, req, longint'(valid), 1);
    @(negedge clk);
  endtask

  task automatic stop_meas();
    meas_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] saved;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    osc_rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(valid == 1'b0, "R1", longint'(valid), 0);
    check(count == 32'd0, "R1", longint'(count), 0);
    check(sat_count == 8'd0, "R1", longint'(sat_count), 0);

    // R2 normal window, oscillator slower than reference
    osc_half = 3.5;
    frun_en = 1'b1;
    win_len = 24'd1024;
    push_band(1024, 7.0, "R2");
    meas_start = 1'b1;
    wait_valid("R2");
    saved = count;
    begin
      int k = 0;
      while (!sat_valid && k < 100) begin @(negedge clk); k++; end
    end
    // R9 8-bit copy saturates at 255
    check(sat_count == 8'hFF, "R9", longint'(sat_count), 255);

    // R3 sticky valid and constant result
    repeat (40) @(negedge clk);
    check(valid == 1'b1, "R3", longint'(valid), 1);
    check(count == saved, "R3", longint'(count), longint'(saved));

    // R4 valid drops one edge after clearing
    meas_start = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, "R4", longint'(valid), 0);

    // R5 result held while stopped, cleared on next start
    repeat (10) @(negedge clk);
    check(count == saved, "R5", longint'(count), longint'(saved));
    osc_half = 1.5;
    win_len = 24'd37;
    push_band(37, 3.0, "R2");
    meas_start = 1'b1;
    @(negedge clk);
    check(count == 32'd0, "R5", longint'(count), 0);
    wait_valid("R2");
    stop_meas();

    // R2 single-cycle window, slow oscillator
    osc_half = 6.5;
    win_len = 24'd1;
    push_band(1, 13.0, "R2");
    meas_start = 1'b1;
    wait_valid("R2");
    stop_meas();

    // R6 zero-length window
    win_len = 24'd0;
    push_band(0, 13.0, "R6");
    meas_start = 1'b1;
    @(negedge clk);
    check(valid == 1'b1, "R6", longint'(valid), 1);
    check(count == 32'd0, "R6", longint'(count), 0);
    stop_meas();

    // R7 gate held low, then opened
    osc_half = 3.5;
    frun_en = 1'b0;
    win_len = 24'd200;
    push_band(200, 7.0, "R7");
    meas_start = 1'b1;
    repeat (300) @(negedge clk);
    check(valid == 1'b0, "R7", longint'(valid), 0);
    frun_en = 1'b1;
    wait_valid("R7");
    stop_meas();

    // R8 abort mid-window, restart with new length
    win_len = 24'd1024;
    meas_start = 1'b1;
    repeat (100) @(negedge clk);
    meas_start = 1'b0;
    repeat (2) @(negedge clk);
    check(valid == 1'b0, "R8", longint'(valid), 0);
    win_len = 24'd50;
    push_band(50, 7.0, "R8");
    meas_start = 1'b1;
    wait_valid("R8");
    check(exp_q.size() == 0, "R8", longint'(exp_q.size()), 0);
    stop_meas();

    finish_run();
  end
endmodule